// File: doc/BRIEF.md
# Fetch and Data Space Selector with Deferred Fetch Switch

This block decides, for every bus cycle of a microcoded 8-bit processor, whether the access goes to the bank-switched ROM or to RAM. Option ROM banks overlay the low addresses, so the space bit alone decides which memory answers. The selector holds two architectural condition-code bits: a fetch-space bit (1 = ROM) and a data-space bit (1 = RAM). Microcode can only clear the fetch-space bit directly. Both bits can be set to any value by a condition-code restore from the stack, which is how code goes back to ROM after a software-interrupt call returns.

A change of the architectural fetch-space bit does not take effect at once on instruction fetches. It is held back in a shadow latch. The latch copies the architectural bit only when the program counter is loaded from the ALU result, so instructions already in flight keep fetching from the space they started in. Data cycles always use the data-space bit with no delay. The select and the cycle kind are registered, so both are stable for a whole bus cycle.

Top module: `memspace_sel`

## Requirements
- R1: Synchronous reset forces the fetch-space bit, the data-space bit and the shadow latch to 1, forces the select output to ROM (1) and the cycle kind to idle (0). The first fetch after reset selects ROM.
- R2: A clear strobe makes the fetch-space bit 0 on the next cycle. No input other than a restore can set it back to 1.
- R3: A restore strobe loads the fetch-space bit from rest_f_i and the data-space bit from rest_d_i on the next cycle.
- R4: When a restore and a clear arrive in the same cycle, the restored value wins.
- R5: A fetch cycle uses the shadow latch. A change to the fetch-space bit does not alter fetches made before the next PC-from-ALU load, including a fetch in the same cycle as the change.
- R6: A PC-from-ALU strobe copies the new fetch-space value (the value the bit takes at that edge) into the shadow latch. The latch holds in every other cycle.
- R7: When a restore and a PC-from-ALU load happen in the same cycle, the restored fetch-space value goes into the shadow latch.
- R8: A data cycle selects ROM exactly when the current data-space bit is 0, with no delay.
- R9: The select and cycle kind appear one clock after the cycle request. In a cycle with no request the kind is idle (0) and the select holds its last value.
- R10: Cycle kind encoding is 0 idle, 1 fetch, 2 data. When fetch and data requests are both asserted, the fetch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_f_i | input | 1 | Microcode strobe that clears the fetch-space bit |
| cc_rest_i | input | 1 | Condition-code restore strobe |
| rest_f_i | input | 1 | Fetch-space value being restored |
| rest_d_i | input | 1 | Data-space value being restored |
| pc_alu_i | input | 1 | PC loaded from ALU output this cycle |
| fetch_cyc_i | input | 1 | Current bus cycle is an instruction fetch |
| data_cyc_i | input | 1 | Current bus cycle is a data access |
| bus_rom_o | output | 1 | Registered select, 1 = ROM, 0 = RAM |
| bus_kind_o | output | 2 | Registered cycle kind (0 idle, 1 fetch, 2 data) |
| cc_f_o | output | 1 | Architectural fetch-space bit |
| cc_d_o | output | 1 | Architectural data-space bit |

## Verification
Each strobe and request is applied for one cycle, and its results are due one edge later: the architectural bits, the shadow latch and the registered select all update on that single edge. The bench drives on the falling edge and samples just after the next rising edge, so each vector's expected values describe the state one edge after its inputs. The deferred switch is checked over several vectors: a fetch with a strobe in the same cycle, fetches after the change but before a PC load, and the first fetch after the PC load, where the new space is due.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_DATA  = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic f;   // 1 = fetch from ROM
        logic d;   // 1 = data from RAM
    } space_bits_t;

    localparam space_bits_t SPACE_RESET = '{f: 1'b1, d: 1'b1};
    localparam logic        SHADOW_RESET = 1'b1;
    localparam logic        ROM_SEL_RESET = 1'b1;

    // Fetch requests take priority over data requests.
    function automatic cyc_kind_e pick_kind(logic fe, logic da);
        if (fe)      return CYC_FETCH;
        else if (da) return CYC_DATA;
        else         return CYC_IDLE;
    endfunction

endpackage

// File: rtl/cc_space_reg.sv
module cc_space_reg
    import fs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_f,
    input  logic        rest_en,
    input  space_bits_t rest_val,
    output space_bits_t cc_q,
    output logic        f_next
);
    space_bits_t cc_d;

    always_comb begin
        cc_d = cc_q;
        if (rest_en)    cc_d = rest_val;
        else if (clr_f) cc_d.f = 1'b0;
    end

    assign f_next = cc_d.f;

    always_ff @(posedge clk) begin
        if (rst) cc_q <= SPACE_RESET;
        else     cc_q <= cc_d;
    end

    // R1
    cc_reset_chk: assert property (@(posedge clk) rst |=> (cc_q.f && cc_q.d));

    // R2
    f_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_f && !rest_en) |=> !cc_q.f);

    // R2
    f_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!rest_en && !cc_q.f) |=> !cc_q.f);

    // R3
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        rest_en |=> (cc_q == $past(rest_val)));

endmodule

// File: rtl/fetch_shadow.sv
module fetch_shadow
    import fs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic f_in,
    output logic sh_q
);
    always_ff @(posedge clk) begin
        if (rst)       sh_q <= SHADOW_RESET;
        else if (load) sh_q <= f_in;
    end

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(sh_q));

    // R1
    shadow_reset_chk: assert property (@(posedge clk) rst |=> sh_q);

endmodule

// File: rtl/bus_space_out.sv
module bus_space_out
    import fs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fetch_req,
    input  logic      data_req,
    input  logic      fetch_rom,
    input  logic      data_ram,
    output logic      rom_q,
    output cyc_kind_e kind_q
);
    cyc_kind_e kind_d;
    logic      rom_d;

    always_comb begin
        kind_d = pick_kind(fetch_req, data_req);
        unique case (kind_d)
            CYC_FETCH: rom_d = fetch_rom;
            CYC_DATA:  rom_d = ~data_ram;
            default:   rom_d = rom_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_q  <= ROM_SEL_RESET;
            kind_q <= CYC_IDLE;
        end else begin
            rom_q  <= rom_d;
            kind_q <= kind_d;
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req && !data_req) |=> ($stable(rom_q) && kind_q == CYC_IDLE));

    // R10
    fetch_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> (kind_q == CYC_FETCH && rom_q == $past(fetch_rom)));

    // R8
    data_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (data_req && !fetch_req) |=> (rom_q == !$past(data_ram)));

endmodule

// File: rtl/memspace_sel.sv
module memspace_sel
    import fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_f_i,
    input  logic       cc_rest_i,
    input  logic       rest_f_i,
    input  logic       rest_d_i,
    input  logic       pc_alu_i,
    input  logic       fetch_cyc_i,
    input  logic       data_cyc_i,
    output logic       bus_rom_o,
    output logic [1:0] bus_kind_o,
    output logic       cc_f_o,
    output logic       cc_d_o
);
    space_bits_t rest_val;
    space_bits_t cc_q;
    logic        f_next;
    logic        sh_q;
    cyc_kind_e   kind_q;

    assign rest_val = '{f: rest_f_i, d: rest_d_i};

    cc_space_reg u_cc (
        .clk      (clk),
        .rst      (rst),
        .clr_f    (clr_f_i),
        .rest_en  (cc_rest_i),
        .rest_val (rest_val),
        .cc_q     (cc_q),
        .f_next   (f_next)
    );

    fetch_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .load (pc_alu_i),
        .f_in (f_next),
        .sh_q (sh_q)
    );

    bus_space_out u_out (
        .clk       (clk),
        .rst       (rst),
        .fetch_req (fetch_cyc_i),
        .data_req  (data_cyc_i),
        .fetch_rom (sh_q),
        .data_ram  (cc_q.d),
        .rom_q     (bus_rom_o),
        .kind_q    (kind_q)
    );

    assign bus_kind_o = kind_q;
    assign cc_f_o     = cc_q.f;
    assign cc_d_o     = cc_q.d;

    // R7
    restore_into_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        (cc_rest_i && pc_alu_i) |=> (sh_q == $past(rest_f_i)));

    // R5
    deferred_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_alu_i && fetch_cyc_i) |=> (bus_rom_o == sh_q));

endmodule

// File: tb/sim_memspace_sel.sv
module sim_memspace_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_f_i = 1'b0, cc_rest_i = 1'b0, rest_f_i = 1'b0, rest_d_i = 1'b0;
    logic       pc_alu_i = 1'b0, fetch_cyc_i = 1'b0, data_cyc_i = 1'b0;
    logic       bus_rom_o;
    logic [1:0] bus_kind_o;
    logic       cc_f_o, cc_d_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    memspace_sel u0 (
        .clk(clk), .rst(rst), .clr_f_i(clr_f_i), .cc_rest_i(cc_rest_i),
        .rest_f_i(rest_f_i), .rest_d_i(rest_d_i), .pc_alu_i(pc_alu_i),
        .fetch_cyc_i(fetch_cyc_i), .data_cyc_i(data_cyc_i),
        .bus_rom_o(bus_rom_o), .bus_kind_o(bus_kind_o),
        .cc_f_o(cc_f_o), .cc_d_o(cc_d_o)
    );

    // Row: inputs {rst,clr,rest,rf,rd,pc,fetch,data}, expected {kind,rom,ccf,ccd}
    localparam int NV = 23;
    localparam logic [12:0] VEC [NV] = '{
        {8'b1000_0000, 2'd0, 1'b1, 1'b1, 1'b1},  // 0  R1 reset
        {8'b0000_0010, 2'd1, 1'b1, 1'b1, 1'b1},  // 1  R1 first fetch ROM
        {8'b0000_0001, 2'd2, 1'b0, 1'b1, 1'b1},  // 2  R8 data D=1 -> RAM
        {8'b0100_0010, 2'd1, 1'b1, 1'b0, 1'b1},  // 3  R2 R5 clear, same-cycle fetch old space
        {8'b0000_0010, 2'd1, 1'b1, 1'b0, 1'b1},  // 4  R5 still old space
        {8'b0000_0100, 2'd0, 1'b1, 1'b0, 1'b1},  // 5  R6 R9 pc load, idle hold
        {8'b0000_0010, 2'd1, 1'b0, 1'b0, 1'b1},  // 6  R6 fetch from RAM
        {8'b0000_0001, 2'd2, 1'b0, 1'b0, 1'b1},  // 7  R8
        {8'b0011_0010, 2'd1, 1'b0, 1'b1, 1'b0},  // 8  R3 R5 restore f=1 d=0
        {8'b0000_0001, 2'd2, 1'b1, 1'b1, 1'b0},  // 9  R8 D=0 -> ROM
        {8'b0000_0011, 2'd1, 1'b0, 1'b1, 1'b0},  // 10 R10 fetch wins
        {8'b0000_0110, 2'd1, 1'b0, 1'b1, 1'b0},  // 11 R5 pc+fetch uses old latch
        {8'b0000_0010, 2'd1, 1'b1, 1'b1, 1'b0},  // 12 R6 back in ROM
        {8'b0111_1000, 2'd0, 1'b1, 1'b1, 1'b1},  // 13 R4 restore beats clear
        {8'b0100_0000, 2'd0, 1'b1, 1'b0, 1'b1},  // 14 R2
        {8'b0010_1100, 2'd0, 1'b1, 1'b0, 1'b1},  // 15 R7 restore f=0 with pc load
        {8'b0000_0010, 2'd1, 1'b0, 1'b0, 1'b1},  // 16 R7
        {8'b0111_1100, 2'd0, 1'b0, 1'b1, 1'b1},  // 17 R4 R7 restore+clear+pc
        {8'b0000_0010, 2'd1, 1'b1, 1'b1, 1'b1},  // 18 R7
        {8'b0000_0001, 2'd2, 1'b0, 1'b1, 1'b1},  // 19 R8
        {8'b0100_0100, 2'd0, 1'b0, 1'b0, 1'b1},  // 20 R6 clear+pc
        {8'b1000_0000, 2'd0, 1'b1, 1'b1, 1'b1},  // 21 R1 reset
        {8'b0000_0010, 2'd1, 1'b1, 1'b1, 1'b1}   // 22 R1 shadow reset to ROM
    };
    localparam int REQ [NV] = '{1,1,8,2,5,6,6,8,3,8,10,5,6,4,2,7,7,4,7,8,6,1,1};

    task automatic check(input int req, input logic [4:0] got, input logic [4:0] exp,
                         input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [7:0] v);
        {rst, clr_f_i, cc_rest_i, rest_f_i, rest_d_i, pc_alu_i, fetch_cyc_i, data_cyc_i} = v;
    endtask

    initial begin
        @(posedge clk); #1;
        check(1, {bus_kind_o, bus_rom_o, cc_f_o, cc_d_o}, 5'b00_111, "initial reset state");
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][12:5]);
            @(posedge clk); #1;
            check(REQ[i], {bus_kind_o, bus_rom_o, cc_f_o, cc_d_o}, VEC[i][4:0],
                  $sformatf("vector %0d", i));
        end

        // R2: clear, then idle cycles never set F again; R9: select holds while idle
        @(negedge clk); drive(8'b0100_0001);   // clear + data (D=1 -> RAM)
        @(posedge clk); #1;
        check(2, {bus_kind_o, bus_rom_o, cc_f_o, cc_d_o}, 5'b10_001, "clear with data");
        @(negedge clk); drive(8'b0000_0000);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check(9, {bus_kind_o, bus_rom_o, cc_f_o, cc_d_o}, 5'b00_001, "idle hold");
        end
        // R5: fetches before a PC load still come from ROM
        @(negedge clk); drive(8'b0000_0010);
        @(posedge clk); #1;
        check(5, {bus_kind_o, bus_rom_o, cc_f_o, cc_d_o}, 5'b01_101, "fetch before pc load");
        @(negedge clk); drive(8'b0000_0100);
        @(posedge clk); #1;
        @(negedge clk); drive(8'b0000_0010);
        @(posedge clk); #1;
        check(6, {bus_kind_o, bus_rom_o, cc_f_o, cc_d_o}, 5'b01_001, "fetch after pc load");
        @(negedge clk); drive(8'b0000_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule